// File: doc/BRIEF.md
# Serial EEPROM Three-Wire Host Controller

This block is a host-side master for a three-wire serial EEPROM with chip select, serial clock, data in and data out. A user places an instruction code, an address and, where needed, a write word on the command inputs, then pulses `start`. The controller derives the serial clock from the system clock, raises chip select and shifts out a frame. The frame is a start bit, a two-bit opcode, the full address field and, for the two data-carrying instructions, the write word. For a read, it drops the leading dummy bit the memory returns and collects the data word. Each transaction ends with a one-cycle `done` pulse.

After any programming instruction, the controller lowers chip select so that the memory begins its internal write. It then raises chip select again with the serial clock held low and watches the data-out line until the memory reports ready. If that takes too long, it gives up and flags a timeout on `done`. While a transaction is in flight, `busy` is high and further `start` pulses have no effect.

The controller is a single state machine with nine states:

| State | Role | Exit |
|---|---|---|
| S_IDLE | Waits for work. | An accepted `start` moves it to S_GAP. |
| S_GAP | Holds chip select low for one full serial-clock period. | Moves to S_TX_LO. |
| S_TX_LO / S_TX_HI | Send one frame bit per low/high pair. | After the last bit, a read goes to S_RX_LO, a programming instruction goes to S_PGAP, and anything else goes to S_DONE. |
| S_RX_LO / S_RX_HI | Collect one data bit per pair. | After the last data bit, moves to S_DONE. |
| S_PGAP | Keeps chip select low for one serial period. | Moves to S_POLL. |
| S_POLL | Chip select high, clock idle, samples ready once per half period. | Exits to S_DONE on ready or on timeout. |
| S_DONE | Pulses `done`. | Returns to S_IDLE. |

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, `ew_cs`, `ew_sk`, `ew_di`, `busy`, `done` and `timeout_err` are all 0.
- R2: Each frame sends a 1 start bit, then a two-bit opcode, then all ADDR_W address bits, every field most significant bit first. The command codes map as follows: 0 read (opcode 10), 1 write (01), 2 erase (11), 3 enable, 4 disable, 5 erase-all, 6 write-all. Codes 3 to 6 use opcode 00 and carry a control code in the top two address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all. The remaining address bits are 0. Code 7 is sent as disable.
- R3: Write and write-all frames append the DATA_W-bit write word, most significant bit first, for 3+ADDR_W+DATA_W clock pulses. Erase, enable, disable and erase-all send exactly 3+ADDR_W pulses.
- R4: `ew_sk` stays high for exactly HALF_DIV system clocks per pulse, and `ew_di` does not change while `ew_sk` is high.
- R5: On a read, the bit sampled at the falling clock edge after the last address bit is discarded. The next DATA_W bits are sampled on the following falling edges and appear on `rd_data` most significant bit first. `rd_data` holds its value while idle.
- R6: Chip select is low for at least 2*HALF_DIV system clocks before every rise, and `ew_sk` is never high while `ew_cs` is low.
- R7: After write, erase, erase-all or write-all, chip select falls, then rises again with `ew_sk` held low and no clock pulses. `ew_do` is sampled once per half period, and a 1 ends the transaction.
- R8: If ready has not been seen after POLL_LIMIT system clocks of polling, the transaction ends with `timeout_err` high during `done`. Otherwise `timeout_err` is 0.
- R9: `busy` rises the cycle after an accepted `start` and stays high until `done`. `done` lasts one cycle, and `busy` is low the cycle after it.
- R10: A `start` pulse while `busy` is high has no effect: it produces no frame and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| cmd_op | input | 3 | Instruction code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write word for write and write-all |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Ready poll timed out, valid with `done` |
| rd_data | output | DATA_W | Last word read |
| ew_cs | output | 1 | Chip select to the memory |
| ew_sk | output | 1 | Serial clock to the memory |
| ew_di | output | 1 | Serial data to the memory |
| ew_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench builds the controller with ADDR_W=6, DATA_W=16, HALF_DIV=2 and POLL_LIMIT=300. The short six-bit address makes the two extreme addresses, 0 and 63, and a full memory sweep for the bulk instructions cheap to check against a behavioural memory model. A two-clock half period puts every clock edge, chip-select gap and sampling point within a few system cycles, so the bench can measure them exactly. The small poll limit lets the bench force a timeout with a slow memory within a couple of thousand cycles, next to normal programming delays that finish well inside the limit.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_WREN      = 3'd3,
        OP_WRDIS     = 3'd4,
        OP_ERASE_ALL = 3'd5,
        OP_FILL_ALL  = 3'd6
    } mw_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GAP,
        S_TX_LO,
        S_TX_HI,
        S_RX_LO,
        S_RX_HI,
        S_PGAP,
        S_POLL,
        S_DONE
    } mw_state_e;

    function automatic logic [1:0] cmd_opcode(input mw_cmd_e c);
        unique case (c)
            OP_READ:  return 2'b10;
            OP_WRITE: return 2'b01;
            OP_ERASE: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] cmd_ctrl(input mw_cmd_e c);
        unique case (c)
            OP_WREN:      return 2'b11;
            OP_ERASE_ALL: return 2'b10;
            OP_FILL_ALL:  return 2'b01;
            default:      return 2'b00;
        endcase
    endfunction

    function automatic logic cmd_has_data(input mw_cmd_e c);
        return (c == OP_WRITE) || (c == OP_FILL_ALL);
    endfunction

    function automatic logic cmd_polls(input mw_cmd_e c);
        return (c == OP_WRITE) || (c == OP_ERASE) ||
               (c == OP_ERASE_ALL) || (c == OP_FILL_ALL);
    endfunction

endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
    import mw_host_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic [2:0]                   op,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [3+ADDR_W+DATA_W-1:0]   frame,
    output logic [CNT_W-1:0]             nbits
);
    localparam int HDR_BITS = 3 + ADDR_W;

    mw_cmd_e             c;
    logic [ADDR_W-1:0]   afield;

    always_comb begin
        c = mw_cmd_e'(op);
        if (cmd_opcode(c) == 2'b00) begin
            afield = {cmd_ctrl(c), {(ADDR_W-2){1'b0}}};
        end else begin
            afield = addr;
        end
        frame = {1'b1, cmd_opcode(c), afield, wdata};
        nbits = cmd_has_data(c) ? CNT_W'(HDR_BITS + DATA_W) : CNT_W'(HDR_BITS);
    end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
    import mw_host_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int HALF_DIV   = 50,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              ew_cs,
    output logic              ew_sk,
    output logic              ew_di,
    input  logic              ew_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int POLL_W  = $clog2(POLL_LIMIT + 2);
    localparam logic [POLL_W-1:0] POLL_MAX = POLL_W'(POLL_LIMIT);

    mw_state_e            state, state_nx;
    mw_cmd_e              op_q;
    logic [FRAME_W-1:0]   frame_q, frame_new;
    logic [CNT_W-1:0]     left_q, nbits_new;
    logic                 gap_q;
    logic [POLL_W-1:0]    poll_q;
    logic [DATA_W-1:0]    rd_q;
    logic                 err_q;
    logic                 tick;
    logic                 last_bit;

    mw_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state != S_IDLE),
        .tick (tick)
    );

    mw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_build (
        .op   (cmd_op),
        .addr (cmd_addr),
        .wdata(cmd_wdata),
        .frame(frame_new),
        .nbits(nbits_new)
    );

    assign last_bit = (left_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_GAP;
            S_GAP:   if (tick && gap_q) state_nx = S_TX_LO;
            S_TX_LO: if (tick) state_nx = S_TX_HI;
            S_TX_HI: if (tick) begin
                         if (!last_bit)           state_nx = S_TX_LO;
                         else if (op_q == OP_READ) state_nx = S_RX_LO;
                         else if (cmd_polls(op_q)) state_nx = S_PGAP;
                         else                      state_nx = S_DONE;
                     end
            S_RX_LO: if (tick) state_nx = S_RX_HI;
            S_RX_HI: if (tick) state_nx = last_bit ? S_DONE : S_RX_LO;
            S_PGAP:  if (tick && gap_q) state_nx = S_POLL;
            S_POLL:  if (tick && (ew_do || poll_q >= POLL_MAX)) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            frame_q <= '0;
            left_q  <= '0;
            gap_q   <= 1'b0;
            poll_q  <= '0;
            rd_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q    <= mw_cmd_e'(cmd_op);
                    frame_q <= frame_new;
                    left_q  <= nbits_new;
                    gap_q   <= 1'b0;
                    err_q   <= 1'b0;
                end
                S_GAP, S_PGAP: begin
                    if (tick) gap_q <= ~gap_q;
                    poll_q <= '0;
                end
                S_TX_HI: if (tick) begin
                    if (last_bit) begin
                        left_q <= CNT_W'(DATA_W);   // dummy bit dropped here
                    end else begin
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        left_q  <= left_q - 1'b1;
                    end
                end
                S_RX_HI: if (tick) begin
                    rd_q   <= {rd_q[DATA_W-2:0], ew_do};
                    left_q <= left_q - 1'b1;
                end
                S_POLL: begin
                    poll_q <= poll_q + 1'b1;
                    if (tick && !ew_do && poll_q >= POLL_MAX) err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ew_cs       = (state == S_TX_LO) || (state == S_TX_HI) ||
                      (state == S_RX_LO) || (state == S_RX_HI) || (state == S_POLL);
        ew_sk       = (state == S_TX_HI) || (state == S_RX_HI);
        ew_di       = ((state == S_TX_LO) || (state == S_TX_HI)) ? frame_q[FRAME_W-1] : 1'b0;
        busy        = (state != S_IDLE);
        done        = (state == S_DONE);
        timeout_err = (state == S_DONE) && err_q;
        rd_data     = rd_q;
    end
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic              ew_cs,
    input logic              ew_sk,
    input logic              ew_di
);
    AST_IDLE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ew_cs); // R6

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ew_sk |-> ew_cs); // R6

    AST_DI_HOLD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ew_sk && $past(ew_sk)) |-> $stable(ew_di)); // R4

    AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ew_cs) |-> !ew_sk); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

    AST_RD_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data)); // R5
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.DATA_W(DATA_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .rd_data(rd_data),
    .ew_cs  (ew_cs),
    .ew_sk  (ew_sk),
    .ew_di  (ew_di)
);

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int HALF = 2;
    localparam int PLIM = 300;
    localparam int HB   = 2 + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, done, timeout_err, ew_cs, ew_sk, ew_di, ew_do;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    mw_eeprom_host #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(HALF), .POLL_LIMIT(PLIM)) i_mw_eeprom_host (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .timeout_err(timeout_err),
        .rd_data(rd_data), .ew_cs(ew_cs), .ew_sk(ew_sk), .ew_di(ew_di), .ew_do(ew_do)
    );

    // ---------------- behavioural memory ----------------
    logic [DW-1:0] mem [0:63];
    logic          prev_sk, prev_cs, started, reading, rd_bit, wen;
    int            nb, ndat, edges, last_edges, zero_win, busy_cnt, busy_len;
    logic [HB-1:0] hdr, nh, last_hdr;
    logic [DW-1:0] dat, rword;

    assign ew_do = ew_cs ? (reading ? rd_bit : (busy_cnt == 0)) : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            prev_sk <= 0; prev_cs <= 0; started <= 0; reading <= 0; rd_bit <= 0; wen <= 0;
            nb <= 0; ndat <= 0; edges <= 0; last_edges <= 0; zero_win <= 0; busy_cnt <= 0;
            hdr <= '0; last_hdr <= '0; dat <= '0; rword <= '0;
        end else begin
            prev_sk <= ew_sk;
            prev_cs <= ew_cs;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (ew_cs && !prev_cs) begin
                started <= 0; nb <= 0; ndat <= 0; reading <= 0; edges <= 0;
            end else if (ew_cs && ew_sk && !prev_sk) begin
                edges <= edges + 1;
                if (!started) begin
                    if (ew_di) started <= 1;
                end else if (nb < HB) begin
                    nh = {hdr[HB-2:0], ew_di};
                    hdr <= nh;
                    nb <= nb + 1;
                    if (nb == HB - 1 && nh[AW+1:AW] == 2'b10) begin
                        reading <= 1; rd_bit <= 0; rword <= mem[nh[AW-1:0]];
                    end
                end else if (reading) begin
                    rd_bit <= rword[DW-1];
                    rword  <= {rword[DW-2:0], 1'b0};
                end else begin
                    dat  <= {dat[DW-2:0], ew_di};
                    ndat <= ndat + 1;
                end
            end else if (!ew_cs && prev_cs) begin
                if (edges == 0) zero_win <= zero_win + 1;
                else begin last_hdr <= hdr; last_edges <= edges; end
                if (started && nb == HB) begin
                    unique case (hdr[AW+1:AW])
                        2'b01: if (wen && ndat == DW) begin mem[hdr[AW-1:0]] <= dat; busy_cnt <= busy_len; end
                        2'b11: if (wen) begin mem[hdr[AW-1:0]] <= '1; busy_cnt <= busy_len; end
                        2'b00: unique case (hdr[AW-1:AW-2])
                            2'b11: wen <= 1;
                            2'b00: wen <= 0;
                            2'b10: if (wen) begin
                                for (int i = 0; i < 64; i++) mem[i] <= '1;
                                busy_cnt <= busy_len;
                            end
                            default: if (wen && ndat == DW) begin
                                for (int i = 0; i < 64; i++) mem[i] <= dat;
                                busy_cnt <= busy_len;
                            end
                        endcase
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- interface timing monitor ----------------
    int sk_run, low_run, sk_bad, di_bad, gap_bad, skcs_bad, done_bad, done_cnt;
    logic m_sk, m_cs, m_di, m_done;
    initial begin
        sk_run = 0; low_run = 0; sk_bad = 0; di_bad = 0; gap_bad = 0;
        skcs_bad = 0; done_bad = 0; done_cnt = 0;
        m_sk = 0; m_cs = 0; m_di = 0; m_done = 0;
    end
    always @(negedge clk) if (rst_n) begin
        if (ew_sk) sk_run++;
        else if (m_sk) begin if (sk_run != HALF) sk_bad++; sk_run = 0; end
        if (ew_sk && m_sk && ew_di != m_di) di_bad++;
        if (!ew_cs) low_run++;
        else if (!m_cs) begin if (low_run < 2 * HALF) gap_bad++; low_run = 0; end
        if (ew_sk && !ew_cs) skcs_bad++;
        if (done && m_done) done_bad++;
        if (done) done_cnt++;
        m_sk = ew_sk; m_cs = ew_cs; m_di = ew_di; m_done = done;
    end

    // ---------------- checking helpers ----------------
    int total = 0, bad = 0;
    logic [DW-1:0] res_rd;
    logic          res_err;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        bit got = 0;
        for (int n = 0; n < 20000 && !got; n++) begin
            @(negedge clk);
            if (done) begin got = 1; res_rd = rd_data; res_err = timeout_err; end
        end
        if (!got) chk("R9", "done never seen", 0, 1);
    endtask

    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; start = 1;
        @(negedge clk);
        start = 0;
        chk("R9", "busy after start", busy, 1);
        wait_done();
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs", ew_cs, 0); chk("R1", "sk", ew_sk, 0); chk("R1", "di", ew_di, 0);
        chk("R1", "busy", busy, 0); chk("R1", "done", done, 0); chk("R1", "err", timeout_err, 0);
    endtask

    task automatic t_enable();
        issue(3'd3, 6'h2A, '0);
        chk("R2", "enable header", last_hdr, {2'b00, 2'b11, 4'b0});
        chk("R3", "enable pulses", last_edges, 3 + AW);
        chk("R8", "enable err", res_err, 0);
    endtask

    task automatic t_write_read();
        int zw = zero_win;
        issue(3'd1, 6'd5, 16'hA5C3);
        chk("R2", "write header", last_hdr, {2'b01, 6'd5});
        chk("R3", "write pulses", last_edges, 3 + AW + DW);
        chk("R7", "poll window seen", zero_win > zw, 1);
        chk("R8", "write err", res_err, 0);
        issue(3'd0, 6'd5, '0);
        chk("R2", "read header", last_hdr, {2'b10, 6'd5});
        chk("R3", "read pulses", last_edges, 3 + AW + DW);
        chk("R5", "read word", res_rd, 16'hA5C3);
    endtask

    task automatic t_edge_pattern();
        issue(3'd1, 6'd63, 16'h8001);
        issue(3'd0, 6'd63, '0);
        chk("R5", "read 8001 at top addr", res_rd, 16'h8001);
        issue(3'd0, 6'd0, '0);
        chk("R5", "read unwritten addr 0", res_rd, 16'h0000);
    endtask

    task automatic t_erase();
        issue(3'd2, 6'd5, 16'h1111);
        chk("R2", "erase header", last_hdr, {2'b11, 6'd5});
        chk("R3", "erase pulses", last_edges, 3 + AW);
        issue(3'd0, 6'd5, '0);
        chk("R7", "erased word", res_rd, 16'hFFFF);
    endtask

    task automatic t_fill_and_wipe();
        issue(3'd6, 6'h15, 16'h1234);
        chk("R2", "write-all header", last_hdr, {2'b00, 2'b01, 4'b0});
        chk("R3", "write-all pulses", last_edges, 3 + AW + DW);
        issue(3'd0, 6'd0, '0);  chk("R3", "fill addr 0", res_rd, 16'h1234);
        issue(3'd0, 6'd63, '0); chk("R3", "fill addr 63", res_rd, 16'h1234);
        issue(3'd5, 6'h3F, '0);
        chk("R2", "erase-all header", last_hdr, {2'b00, 2'b10, 4'b0});
        issue(3'd0, 6'd9, '0);  chk("R7", "erase-all addr 9", res_rd, 16'hFFFF);
    endtask

    task automatic t_disable();
        issue(3'd4, 6'h3F, '0);
        chk("R2", "disable header", last_hdr, {2'b00, 2'b00, 4'b0});
        chk("R3", "disable pulses", last_edges, 3 + AW);
        issue(3'd1, 6'd5, 16'h0BAD);
        issue(3'd0, 6'd5, '0);
        chk("R2", "write after disable ignored", res_rd, 16'hFFFF);
    endtask

    task automatic t_timeout();
        issue(3'd3, '0, '0);
        busy_len = 2000;
        issue(3'd1, 6'd7, 16'h7777);
        chk("R8", "timeout flagged", res_err, 1);
        repeat (2100) @(negedge clk);
        busy_len = 60;
        issue(3'd0, 6'd7, '0);
        chk("R8", "err clear on read", res_err, 0);
        chk("R5", "slow write landed", res_rd, 16'h7777);
    endtask

    task automatic t_ignore_start();
        int dc;
        @(negedge clk);
        dc = done_cnt;
        cmd_op = 3'd0; cmd_addr = 6'd9; start = 1;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        cmd_op = 3'd1; cmd_addr = 6'd9; cmd_wdata = 16'h5555; start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
        chk("R10", "read unaffected", res_rd, 16'hFFFF);
        @(negedge clk);
        chk("R9", "busy low after done", busy, 0);
        repeat (200) @(negedge clk);
        chk("R10", "single done", done_cnt - dc, 1);
        issue(3'd0, 6'd9, '0);
        chk("R10", "no stray write", res_rd, 16'hFFFF);
    endtask

    bit finished = 0;

    initial begin
        busy_len = 60;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_enable();
        t_write_read();
        t_edge_pattern();
        t_erase();
        t_fill_and_wipe();
        t_disable();
        t_timeout();
        t_ignore_start();
        chk("R4", "sk high width", sk_bad, 0);
        chk("R4", "di moved while sk high", di_bad, 0);
        chk("R6", "cs low gap", gap_bad, 0);
        chk("R6", "sk without cs", skcs_bad, 0);
        chk("R9", "done wider than one cycle", done_bad, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule